// File: doc/BRIEF.md
# Interrupt status and enable controller

This block gathers interrupt requests from two kinds of source and turns them into one outgoing request toward the serial link. The first source is a level interrupt input from the local bus. The second is a bank of mailbox registers: any write to a mailbox stores the written word and flags that mailbox as a source. Each request is captured in a status register. The status register is combined with a per-bit enable register, and any enabled pending bit drives the outgoing request.

Software works through a small register port that offers single-cycle writes and a combinational read. It reads the status word and services the sources it finds there. It then acknowledges a source by writing a one to that source's status bit. The local input's bit refuses to clear while the input is still high, so the originating peripheral must drop its request first. No request is lost between the service and the acknowledge.

An elaboration parameter selects how the request leaves the block. In level mode a legacy-style level stays high while anything enabled is pending. In message mode a one-cycle request pulse fires each time the enabled-pending condition goes from idle to active. A later stage turns that pulse into a message packet.

Top module: `irq_status_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, the status, enable and mailbox registers read zero, and `legacy_irq` and `msi_req` are low.
- R2: While `local_irq` is high at a rising clock edge, status bit 16 is set from that edge on.
- R3: A write to mailbox i (byte offset 0x3000 + 4*i, i from 0 to MBOX_COUNT-1) stores the full data word, which reads back at the same offset, and sets status bit i.
- R4: A write to the status register (offset 0x3060) clears every implemented status bit written as one and leaves the bits written as zero unchanged.
- R5: A clear of status bit 16 is ignored when `local_irq` is high in the same cycle, and a set and a clear of the same bit in one cycle leave the bit set.
- R6: The enable register at offset 0x3070 reads back what was written on the implemented bits (bits 0 to MBOX_COUNT-1 and bit 16). All other bits read zero.
- R7: In level mode (OUT_MODE = IRQ_OUT_LEVEL), `legacy_irq` is high in the cycle after any status bit and its enable bit are both set, and it stays high for as long as that holds. `msi_req` stays low in this mode.
- R8: In message mode (OUT_MODE = IRQ_OUT_MSG), `msi_req` is high for exactly one cycle, in the cycle after the enabled-pending condition goes from false to true. A further source that becomes pending while the condition is already true gives no new pulse. `legacy_irq` stays low in this mode.
- R9: The status register reads back all pending bits whatever the enable register holds. Reads of unmapped offsets return zero, and writes to unmapped offsets change nothing.
- R10: A pending status bit whose enable bit is clear raises no output. Setting the enable bit later raises the output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| local_irq | input | 1 | Level interrupt request from the local bus |
| reg_wr | input | 1 | Register write strobe, one word per cycle |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the register at `reg_addr` (combinational) |
| legacy_irq | output | 1 | Level interrupt request (level mode) |
| msi_req | output | 1 | One-cycle message request pulse (message mode) |

## Verification
The bench builds two copies of the block side by side with the default widths: 32-bit data, 16-bit offsets and eight mailboxes. One copy uses level mode and the other uses message mode, so both output variants see the same stimulus in the same run. Eight mailboxes put the whole mailbox range and the gap up to the status offset in reach, including the highest mailbox bit next to the unimplemented bits. The source bit at position 16 lets the blocked-clear rule and the enable gating be exercised against a behavioural model on every cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

   // Register map (byte offsets on the control register port)
   localparam int unsigned MBOX_BASE_OFS = 32'h3000;
   localparam int unsigned MBOX_STRIDE   = 4;
   localparam int unsigned STATUS_OFS    = 32'h3060;
   localparam int unsigned ENABLE_OFS    = 32'h3070;

   // Status bit carrying the local-bus interrupt input
   localparam int unsigned SRC_BIT_POS   = 16;

   typedef enum logic {
      IRQ_OUT_LEVEL = 1'b0,
      IRQ_OUT_MSG   = 1'b1
   } irq_out_mode_e;

   function automatic int unsigned mbox_offset(input int unsigned idx);
      return MBOX_BASE_OFS + idx * MBOX_STRIDE;
   endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned MBOX_COUNT = 8
) (
   input  logic                                reg_wr,
   input  logic [ADDR_W-1:0]                   reg_addr,
   input  logic [DATA_W-1:0]                   status_q,
   input  logic [DATA_W-1:0]                   enable_q,
   input  logic [MBOX_COUNT-1:0][DATA_W-1:0]   mbox_q,
   output logic                                stat_wr,
   output logic                                en_wr,
   output logic [MBOX_COUNT-1:0]               mbox_hit,
   output logic [DATA_W-1:0]                   reg_rdata
);

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFS);
   localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(ENABLE_OFS);

   logic                  sel_stat;
   logic                  sel_en;
   logic [MBOX_COUNT-1:0] sel_mbox;

   assign sel_stat = (reg_addr == STAT_A);
   assign sel_en   = (reg_addr == EN_A);

   for (genvar gi = 0; gi < MBOX_COUNT; gi++) begin : g_mbox_sel
      localparam logic [ADDR_W-1:0] MB_A = ADDR_W'(mbox_offset(gi));
      assign sel_mbox[gi] = (reg_addr == MB_A);
      assign mbox_hit[gi] = reg_wr & sel_mbox[gi];
   end

   assign stat_wr = reg_wr & sel_stat;
   assign en_wr   = reg_wr & sel_en;

   always_comb begin
      reg_rdata = '0;
      if (sel_stat) reg_rdata = status_q;
      if (sel_en)   reg_rdata = enable_q;
      for (int i = 0; i < MBOX_COUNT; i++) begin
         if (sel_mbox[i]) reg_rdata = mbox_q[i];
      end
   end

endmodule

// File: rtl/irq_mailbox_bank.sv
module irq_mailbox_bank #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MBOX_COUNT = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [MBOX_COUNT-1:0]             mbox_hit,
   input  logic [DATA_W-1:0]                 wdata,
   output logic [MBOX_COUNT-1:0][DATA_W-1:0] mbox_q
);

   for (genvar gi = 0; gi < MBOX_COUNT; gi++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            mbox_q[gi] <= '0;
         else if (mbox_hit[gi]) mbox_q[gi] <= wdata;
      end

      // R3: a mailbox write lands the word in its slot
      assert_mbox_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
         mbox_hit[gi] |=> (mbox_q[gi] == $past(wdata)));
   end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MBOX_COUNT = 8,
   parameter int unsigned SRC_BIT    = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  src_irq,
   input  logic [MBOX_COUNT-1:0] mbox_hit,
   input  logic                  stat_wr,
   input  logic                  en_wr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     status_q,
   output logic [DATA_W-1:0]     enable_q
);

   localparam logic [DATA_W-1:0] SRC_ONEHOT = DATA_W'(1) << SRC_BIT;
   localparam logic [DATA_W-1:0] MBOX_MASK  = (DATA_W'(1) << MBOX_COUNT) - DATA_W'(1);
   localparam logic [DATA_W-1:0] IMPL_MASK  = SRC_ONEHOT | MBOX_MASK;

   logic [DATA_W-1:0] set_vec;
   logic [DATA_W-1:0] clr_vec;
   logic [DATA_W-1:0] hold_vec;
   logic [DATA_W-1:0] status_d;

   // Requests arriving this cycle
   assign set_vec = (src_irq ? SRC_ONEHOT : '0) | (DATA_W'(mbox_hit) & MBOX_MASK);

   // The source bit may not be acknowledged while its request is still high
   assign hold_vec = src_irq ? SRC_ONEHOT : '0;
   assign clr_vec  = stat_wr ? (wdata & IMPL_MASK & ~hold_vec) : '0;

   // Set wins over clear on the same bit
   assign status_d = ((status_q & ~clr_vec) | set_vec) & IMPL_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         enable_q <= '0;
      end else begin
         status_q <= status_d;
         if (en_wr) enable_q <= wdata & IMPL_MASK;
      end
   end

   assert_src_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      src_irq |=> status_q[SRC_BIT]);

   assert_src_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wdata[SRC_BIT] && !src_irq) |=> !status_q[SRC_BIT]);

   assert_clear_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wdata[SRC_BIT] && src_irq) |=> status_q[SRC_BIT]);

   for (genvar gi = 0; gi < MBOX_COUNT; gi++) begin : g_mbox_chk
      assert_mbox_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
         mbox_hit[gi] |=> status_q[gi]);
   end

endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen
   import irq_ctrl_pkg::*;
#(
   parameter irq_out_mode_e OUT_MODE = IRQ_OUT_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pending,
   output logic legacy_irq,
   output logic msi_req
);

   if (OUT_MODE == IRQ_OUT_MSG) begin : g_msg
      logic pend_q;
      logic pulse_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q  <= 1'b0;
            pulse_q <= 1'b0;
         end else begin
            pend_q  <= pending;
            pulse_q <= pending & ~pend_q;
         end
      end

      assign msi_req    = pulse_q;
      assign legacy_irq = 1'b0;

      assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
         msi_req |=> !msi_req);
   end else begin : g_level
      logic level_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level_q <= 1'b0;
         else        level_q <= pending;
      end

      assign legacy_irq = level_q;
      assign msi_req    = 1'b0;
   end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned   DATA_W     = 32,
   parameter int unsigned   ADDR_W     = 16,
   parameter int unsigned   MBOX_COUNT = 8,
   parameter irq_out_mode_e OUT_MODE   = IRQ_OUT_LEVEL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              local_irq,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              legacy_irq,
   output logic              msi_req
);

   // Elaboration-time parameter checks
   if (ADDR_W < 14 || ADDR_W > 32) begin : g_bad_addr
      $error("irq_status_ctrl: ADDR_W must be 14..32");
   end
   if (DATA_W <= SRC_BIT_POS || DATA_W > 64) begin : g_bad_data
      $error("irq_status_ctrl: DATA_W must exceed the source bit and be at most 64");
   end
   if (MBOX_COUNT < 1 || MBOX_COUNT > SRC_BIT_POS) begin : g_bad_mbox
      $error("irq_status_ctrl: MBOX_COUNT must be 1..16");
   end
   if (mbox_offset(MBOX_COUNT - 1) >= STATUS_OFS) begin : g_bad_map
      $error("irq_status_ctrl: mailbox range overlaps the status register");
   end

   logic                              stat_wr;
   logic                              en_wr;
   logic [MBOX_COUNT-1:0]             mbox_hit;
   logic [DATA_W-1:0]                 status_q;
   logic [DATA_W-1:0]                 enable_q;
   logic [MBOX_COUNT-1:0][DATA_W-1:0] mbox_q;
   logic                              pending_w;

   irq_reg_decode #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .MBOX_COUNT(MBOX_COUNT)
   ) u_decode (
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .status_q (status_q),
      .enable_q (enable_q),
      .mbox_q   (mbox_q),
      .stat_wr  (stat_wr),
      .en_wr    (en_wr),
      .mbox_hit (mbox_hit),
      .reg_rdata(reg_rdata)
   );

   irq_mailbox_bank #(
      .DATA_W    (DATA_W),
      .MBOX_COUNT(MBOX_COUNT)
   ) u_mbox (
      .clk     (clk),
      .rst_n   (rst_n),
      .mbox_hit(mbox_hit),
      .wdata   (reg_wdata),
      .mbox_q  (mbox_q)
   );

   irq_status_bank #(
      .DATA_W    (DATA_W),
      .MBOX_COUNT(MBOX_COUNT),
      .SRC_BIT   (SRC_BIT_POS)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_irq (local_irq),
      .mbox_hit(mbox_hit),
      .stat_wr (stat_wr),
      .en_wr   (en_wr),
      .wdata   (reg_wdata),
      .status_q(status_q),
      .enable_q(enable_q)
   );

   assign pending_w = |(status_q & enable_q);

   irq_out_gen #(
      .OUT_MODE(OUT_MODE)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending   (pending_w),
      .legacy_irq(legacy_irq),
      .msi_req   (msi_req)
   );

   // R10: nothing enabled and pending means no request next cycle
   assert_gated_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pending_w |=> (!legacy_irq && !msi_req));

   // R7: the level only follows an enabled pending bit
   assert_level_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_irq |-> $past(pending_w));

endmodule

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
module irq_status_ctrl_test;
   import irq_ctrl_pkg::*;

   localparam int DW  = 32;
   localparam int AW  = 16;
   localparam int NMB = 8;
   localparam logic [31:0] IMPL = 32'h0001_00FF;
   localparam logic [AW-1:0] A_STAT = 16'h3060;
   localparam logic [AW-1:0] A_EN   = 16'h3070;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic          local_irq;
   logic          reg_wr;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] reg_wdata;
   logic [DW-1:0] rdata_lvl, rdata_msg;
   logic          lvl_lvl, msi_lvl, lvl_msg, msi_msg;

   irq_status_ctrl #(.DATA_W(DW), .ADDR_W(AW), .MBOX_COUNT(NMB), .OUT_MODE(IRQ_OUT_LEVEL)) uut (
      .clk(clk), .rst_n(rst_n), .local_irq(local_irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_lvl), .legacy_irq(lvl_lvl), .msi_req(msi_lvl));

   irq_status_ctrl #(.DATA_W(DW), .ADDR_W(AW), .MBOX_COUNT(NMB), .OUT_MODE(IRQ_OUT_MSG)) uut_msg (
      .clk(clk), .rst_n(rst_n), .local_irq(local_irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_msg), .legacy_irq(lvl_msg), .msi_req(msi_msg));

   // Behavioural reference state
   logic [31:0] m_st, m_en;
   logic [31:0] m_mb [NMB];
   bit          m_lvl, m_msi, m_prev;
   int          checks = 0;
   int          fails  = 0;
   bit          done   = 0;

   function automatic logic [AW-1:0] mb_a(input int i);
      return AW'(32'h3000 + 4 * i);
   endfunction

   function automatic logic [31:0] m_read(input logic [AW-1:0] a);
      logic [31:0] r;
      r = 32'h0;
      if (a == A_STAT) r = m_st;
      if (a == A_EN)   r = m_en;
      for (int i = 0; i < NMB; i++) if (a == mb_a(i)) r = m_mb[i];
      return r;
   endfunction

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      check(tag, "rdata(level)", rdata_lvl, m_read(reg_addr));
      check(tag, "rdata(msg)",   rdata_msg, m_read(reg_addr));
      check({tag, "/R7"}, "legacy_irq(level)", 32'(lvl_lvl), 32'(m_lvl));
      check({tag, "/R7"}, "msi_req(level)",    32'(msi_lvl), 32'h0);
      check({tag, "/R8"}, "legacy_irq(msg)",   32'(lvl_msg), 32'h0);
      check({tag, "/R8"}, "msi_req(msg)",      32'(msi_msg), 32'(m_msi));
   endtask

   // Reference update at one rising edge, given the inputs held over it
   task automatic model_edge(input bit wr, input logic [AW-1:0] a, input logic [31:0] d, input bit irq);
      logic [31:0] set_v, clr_v;
      bit pend;
      pend   = ((m_st & m_en) != 0);
      m_msi  = pend && !m_prev;
      m_prev = pend;
      m_lvl  = pend;
      set_v  = irq ? 32'h0001_0000 : 32'h0;
      clr_v  = 32'h0;
      if (wr) begin
         for (int i = 0; i < NMB; i++) begin
            if (a == mb_a(i)) begin
               m_mb[i] = d;
               set_v   = set_v | (32'h1 << i);
            end
         end
         if (a == A_STAT) clr_v = d & IMPL;
         if (a == A_EN)   m_en  = d & IMPL;
      end
      if (irq) clr_v[16] = 1'b0;
      m_st = (m_st & ~clr_v) | set_v;
   endtask

   // Starts and ends at a falling edge
   task automatic cyc(input bit wr, input logic [AW-1:0] a, input logic [31:0] d, input bit irq, input string tag);
      reg_wr    = wr;
      reg_addr  = a;
      reg_wdata = d;
      local_irq = irq;
      @(posedge clk);
      model_edge(wr, a, d, irq);
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
      cyc(1'b1, a, d, 1'b0, tag);
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag);
      cyc(1'b0, a, 32'h0, 1'b0, tag);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; local_irq = 1'b0; reg_wr = 1'b0; reg_addr = A_STAT; reg_wdata = '0;
      m_st = '0; m_en = '0; m_lvl = 0; m_msi = 0; m_prev = 0;
      for (int i = 0; i < NMB; i++) m_mb[i] = '0;
      repeat (3) @(negedge clk);
      compare_all("R1");
      reg_addr = mb_a(0);
      #1 compare_all("R1");
      @(negedge clk);
      rst_n = 1'b1;

      rd(A_STAT, "R1");
      rd(A_EN, "R1");
      // enable register keeps only implemented bits
      wr(A_EN, 32'hFFFF_FFFF, "R6");
      rd(A_EN, "R6");
      // mailbox 3 write: stored, flagged, output raised
      wr(mb_a(3), 32'hA5A5_0003, "R3");
      rd(A_STAT, "R9");
      rd(mb_a(3), "R3");
      rd(A_STAT, "R7");
      rd(A_STAT, "R8");
      // write-one-to-clear: a zero-effect bit then the real one
      wr(A_STAT, 32'h0000_0004, "R4");
      wr(A_STAT, 32'h0000_0008, "R4");
      repeat (3) rd(A_STAT, "R7");
      // local input source and blocked acknowledge
      cyc(1'b0, A_STAT, 32'h0, 1'b1, "R2");
      cyc(1'b0, A_STAT, 32'h0, 1'b1, "R2");
      cyc(1'b1, A_STAT, 32'h0001_0000, 1'b1, "R5");
      cyc(1'b0, A_STAT, 32'h0, 1'b0, "R5");
      wr(A_STAT, 32'h0001_0000, "R4");
      repeat (2) rd(A_STAT, "R4");
      // enable gating
      wr(A_EN, 32'h0, "R10");
      wr(mb_a(5), 32'h5555_0005, "R10");
      repeat (2) rd(A_STAT, "R10");
      rd(A_STAT, "R9");
      wr(A_EN, 32'h0000_0020, "R10");
      repeat (3) rd(A_STAT, "R8");
      // overlapping sources give one message pulse
      wr(A_EN, IMPL, "R6");
      wr(mb_a(0), 32'h0000_0100, "R8");
      wr(mb_a(7), 32'h7777_0007, "R8");
      wr(A_STAT, 32'h0000_0020, "R4");
      rd(A_STAT, "R8");
      wr(A_STAT, 32'h0000_0081, "R4");
      repeat (2) rd(A_STAT, "R8");
      wr(mb_a(1), 32'h1111_0001, "R8");
      repeat (2) rd(A_STAT, "R8");
      // unmapped offsets
      rd(16'h3064, "R9");
      rd(16'h3080, "R9");
      wr(16'h3064, 32'hFFFF_FFFF, "R9");
      rd(A_STAT, "R9");
      rd(A_EN, "R9");
      // every mailbox slot
      for (int i = 0; i < NMB; i++) begin
         wr(mb_a(i), 32'h1234_0000 + 32'(i * 32'h0101), "R3");
         rd(mb_a(i), "R3");
      end
      wr(A_STAT, 32'hFFFF_FFFF, "R4");
      repeat (3) rd(A_STAT, "R4");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule